// File: doc/BRIEF.md
# Road Queues with Red-Light Violation Log

This block keeps track of the cars waiting on two one-way roads that meet at a signalled crossing. Each road has its own first-in first-out queue of 5-bit plate numbers. A detector raises an action strobe, and a 3-bit command selects what that strobe does. It can enqueue the presented plate on either road, or it can dequeue the front car of either road. When a car leaves a road while that road's light is red, its plate is recorded in a shared violation log. Entries go into the log in the order the offences happened.

The light state and a once-a-day midnight pulse come from neighbouring logic. The midnight pulse empties the violation log. When the top command bit is set, the block is in review mode and walks the violation log on the clock, one plate per cycle, with wrap-around. Each time review mode is entered, the walk starts again from the oldest entry. Outside review mode, the plate output freezes on the last value shown.

Top module: `lane_violation_tracker`

## Requirements
- R1: After reset, both car counts and the plate output are 0.
- R2: The action input is sampled on the clock, and an operation fires on the first clock at which it is seen high after being low. With command 3'b010 the plate is appended to road A; with 3'b011 it is appended to road B. The count of that road rises by one after that clock.
- R3: With command 3'b000 the oldest car of road A leaves; with 3'b001 the oldest car of road B leaves. The plate input is ignored, cars leave in arrival order, and the count falls by one.
- R4: Holding action high over several clocks performs only one operation.
- R5: A departure while that road's green input is low appends the departing plate to the violation log, in offence order. A departure during green leaves the log unchanged.
- R6: While command bit 2 is 1, each clock shows the next logged plate in insertion order, returning to the oldest after the newest.
- R7: Every new entry into review mode starts the walk from the oldest logged plate.
- R8: In review mode, an empty log shows 0, and a log with a single entry shows that plate on every cycle.
- R9: While command bit 2 is 0 and no midnight pulse arrives, the plate output keeps its last value.
- R10: A midnight pulse empties the log and drives the plate output to 0. It takes priority over a violation recorded in the same cycle.
- R11: Action strobes given while in review mode change neither queue nor the log.
- R12: An append to a road holding 30 cars is dropped. A departure from an empty road is dropped. A violation beyond 30 logged plates is not recorded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode | input | 3 | Command: 010/011 append to A/B, 000/001 depart from A/B, 1xx review |
| plate_in | input | 5 | Plate to append (nonzero) |
| action | input | 1 | Operation strobe, rising edge sampled on clk |
| green_a | input | 1 | Road A light is green |
| green_b | input | 1 | Road B light is green |
| midnight | input | 1 | One-cycle pulse that clears the violation log |
| cars_a | output | 5 | Cars queued on road A |
| cars_b | output | 5 | Cars queued on road B |
| shown | output | 5 | Plate shown from the violation log |

## Verification
The assertions check on every cycle the rules that hold locally. Counts stay within their bounds and move by exactly one on an accepted append or departure. Counts stay still when an append hits a full road, when action is held high, and while in review mode. A midnight pulse clears the log, the review output freezes outside review mode, and an empty log shows 0. Other behaviour depends on the order of events over many operations, so only the bench scenarios can show it. This covers the arrival order of departures, the offence order of the log, the wrap-around of the review walk, and the restart from the oldest entry on each new review.

// File: rtl/lvt_pkg.sv
package lvt_pkg;
  localparam int PLATE_W   = 5;
  localparam int ROAD_DEPTH = 30;
  localparam int LOG_DEPTH  = 30;

  typedef enum logic [1:0] {
    CMD_LEAVE_A = 2'b00,
    CMD_LEAVE_B = 2'b01,
    CMD_ENTER_A = 2'b10,
    CMD_ENTER_B = 2'b11
  } road_cmd_e;
endpackage

// File: rtl/plate_fifo.sv
module plate_fifo #(
  parameter int W     = 5,
  parameter int DEPTH = 30
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic                       pop,
  input  logic [W-1:0]               din,
  output logic [W-1:0]               head,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       empty
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rd_q, rd_d, wr_q, wr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          full, do_push, do_pop;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_comb begin
    rd_d  = rd_q;
    wr_d  = wr_q;
    cnt_d = cnt_q;
    if (do_push) wr_d = bump(wr_q);
    if (do_pop)  rd_d = bump(rd_q);
    case ({do_push, do_pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= din;
  end

  assign head  = mem[rd_q];
  assign count = cnt_q;

  // R12: occupancy never passes the depth
  p_count_bound_r12: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  // R2: an accepted append grows the count by one
  p_push_grow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && count != CW'(DEPTH)) |=> count == $past(count) + 1'b1);
  // R3: an accepted departure shrinks the count by one
  p_pop_shrink_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && count != '0) |=> count == $past(count) - 1'b1);
  // R12: append to a full road is dropped
  p_full_drop_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && count == CW'(DEPTH)) |=> $stable(count));
endmodule

// File: rtl/violation_log.sv
module violation_log #(
  parameter int W     = 5,
  parameter int DEPTH = 30
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         append,
  input  logic [W-1:0] din,
  input  logic         show_en,
  output logic [W-1:0] shown
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [CW-1:0] fill_q, fill_d;
  logic [PW-1:0] cur_q, cur_d, idx;
  logic [W-1:0]  shown_q, shown_d;
  logic          was_show_q;
  logic          do_append;

  assign do_append = append && !clear && (fill_q != CW'(DEPTH));
  assign idx       = (show_en && !was_show_q) ? '0 : cur_q;

  always_comb begin
    fill_d  = fill_q;
    cur_d   = cur_q;
    shown_d = shown_q;
    if (clear) begin
      fill_d  = '0;
      cur_d   = '0;
      shown_d = '0;
    end else begin
      if (do_append) fill_d = fill_q + 1'b1;
      if (show_en) begin
        shown_d = (fill_q == '0) ? '0 : mem[idx];
        cur_d   = ((CW'(idx) + 1'b1) >= fill_q) ? '0 : idx + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q     <= '0;
      cur_q      <= '0;
      shown_q    <= '0;
      was_show_q <= 1'b0;
    end else begin
      fill_q     <= fill_d;
      cur_q      <= cur_d;
      shown_q    <= shown_d;
      was_show_q <= show_en;
    end
  end

  always_ff @(posedge clk) begin
    if (do_append) mem[PW'(fill_q)] <= din;
  end

  assign shown = shown_q;

  // R12: log occupancy bounded
  p_log_bound_r12: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= CW'(DEPTH));
  // R10: midnight empties the log and zeroes the output
  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (fill_q == '0 && shown == '0));
  // R9: output frozen outside review mode
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!show_en && !clear) |=> shown == $past(shown));
  // R8: empty log reviews as zero
  p_empty_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (show_en && fill_q == '0) |=> shown == '0);
endmodule

// File: rtl/lane_violation_tracker.sv
module lane_violation_tracker #(
  parameter int W          = lvt_pkg::PLATE_W,
  parameter int ROAD_DEPTH = lvt_pkg::ROAD_DEPTH,
  parameter int LOG_DEPTH  = lvt_pkg::LOG_DEPTH
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [2:0]                      mode,
  input  logic [W-1:0]                    plate_in,
  input  logic                            action,
  input  logic                            green_a,
  input  logic                            green_b,
  input  logic                            midnight,
  output logic [$clog2(ROAD_DEPTH+1)-1:0] cars_a,
  output logic [$clog2(ROAD_DEPTH+1)-1:0] cars_b,
  output logic [W-1:0]                    shown
);
  import lvt_pkg::*;
  localparam int CW = $clog2(ROAD_DEPTH+1);

  logic [1:0]    rst_sync_q;
  logic          core_rst_n;
  logic          act_q;
  logic          fire;
  road_cmd_e     cmd;
  logic [W-1:0]  head  [2];
  logic [CW-1:0] cnt   [2];
  logic [1:0]    empty;
  logic [1:0]    green;
  logic          sel;
  logic          violation;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) act_q <= 1'b0;
    else             act_q <= action;
  end

  assign fire  = action && !act_q && !mode[2];
  assign cmd   = road_cmd_e'(mode[1:0]);
  assign green = {green_b, green_a};
  assign sel   = mode[0];

  for (genvar r = 0; r < 2; r++) begin : g_road
    plate_fifo #(.W(W), .DEPTH(ROAD_DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (core_rst_n),
      .push  (fire && mode[1] && (sel == 1'(r))),
      .pop   (fire && !mode[1] && (sel == 1'(r))),
      .din   (plate_in),
      .head  (head[r]),
      .count (cnt[r]),
      .empty (empty[r])
    );
  end

  assign violation = fire && (cmd == CMD_LEAVE_A || cmd == CMD_LEAVE_B)
                     && !green[sel] && !empty[sel];

  violation_log #(.W(W), .DEPTH(LOG_DEPTH)) u_log (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .clear   (midnight),
    .append  (violation),
    .din     (head[sel]),
    .show_en (mode[2]),
    .shown   (shown)
  );

  assign cars_a = cnt[0];
  assign cars_b = cnt[1];

  // R4: a held strobe triggers nothing further
  p_held_action_r4: assert property (@(posedge clk) disable iff (!core_rst_n)
    (action && act_q) |=> ($stable(cars_a) && $stable(cars_b)));
  // R11: review mode leaves both queues untouched
  p_review_freeze_r11: assert property (@(posedge clk) disable iff (!core_rst_n)
    mode[2] |=> ($stable(cars_a) && $stable(cars_b)));
endmodule

// File: tb/test_lane_violation_tracker.sv
`timescale 1ns/1ps
module test_lane_violation_tracker;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] mode;
  logic [4:0] plate_in;
  logic       action, green_a, green_b, midnight;
  logic [4:0] cars_a, cars_b, shown;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [4:0] qa[$];
  logic [4:0] qb[$];
  logic [4:0] bl[$];

  always #4 clk = ~clk;

  lane_violation_tracker i_lane_violation_tracker (
    .clk(clk), .rst_n(rst_n), .mode(mode), .plate_in(plate_in), .action(action),
    .green_a(green_a), .green_b(green_b), .midnight(midnight),
    .cars_a(cars_a), .cars_b(cars_b), .shown(shown));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] exp_show(input int idx);
    return (bl.size() == 0) ? 5'd0 : bl[idx];
  endfunction

  function automatic int next_idx(input int idx);
    return (idx + 1 >= bl.size()) ? 0 : idx + 1;
  endfunction

  task automatic model_op(input logic [2:0] m, input logic [4:0] p, input logic ga, input logic gb,
                          input bit clr);
    logic [4:0] v;
    case (m[1:0])
      2'b10: if (qa.size() < 30) qa.push_back(p);
      2'b11: if (qb.size() < 30) qb.push_back(p);
      2'b00: if (qa.size() > 0) begin
               v = qa.pop_front();
               if (!ga && !clr && bl.size() < 30) bl.push_back(v);
             end
      default: if (qb.size() > 0) begin
               v = qb.pop_front();
               if (!gb && !clr && bl.size() < 30) bl.push_back(v);
             end
    endcase
    if (clr) bl.delete();
  endtask

  task automatic do_op(input logic [2:0] m, input logic [4:0] p, input logic ga, input logic gb);
    @(negedge clk);
    mode = m; plate_in = p; green_a = ga; green_b = gb; action = 1'b1;
    @(negedge clk);
    action = 1'b0;
    model_op(m, p, ga, gb, 0);
    check(m[1] ? "R2 count A" : "R3 count A", cars_a, qa.size());
    check(m[1] ? "R2 count B" : "R3 count B", cars_b, qb.size());
  endtask

  task automatic pulse_midnight();
    @(negedge clk);
    midnight = 1'b1;
    @(negedge clk);
    midnight = 1'b0;
    bl.delete();
    check("R10 cleared output", shown, 0);
  endtask

  task automatic show_run(input int n, input string tag);
    int idx = 0;
    logic [4:0] last = 0;
    @(negedge clk);
    mode = {1'b1, 2'($urandom_range(0, 3))};
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      last = exp_show(idx);
      check(tag, shown, last);
      idx = next_idx(idx);
    end
    mode = 3'b000;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      check("R9 hold", shown, last);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1d2c3b4a));
    rst_n = 1'b0; mode = 3'b000; plate_in = 5'd0; action = 1'b0;
    green_a = 1'b1; green_b = 1'b0; midnight = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 cars_a", cars_a, 0);
    check("R1 cars_b", cars_b, 0);
    check("R1 shown", shown, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R8: empty review
    show_run(3, "R8 empty shows zero");

    // R2 R3 R5: ordered departures, red ones logged
    do_op(3'b010, 5'd5, 1, 0);
    do_op(3'b010, 5'd6, 1, 0);
    do_op(3'b010, 5'd7, 1, 0);
    do_op(3'b011, 5'd9, 1, 0);
    do_op(3'b000, 5'd31, 0, 1);   // red on A: 5 logged
    do_op(3'b000, 5'd31, 1, 0);   // green on A: 6 not logged
    do_op(3'b001, 5'd0, 1, 0);    // red on B: 9 logged
    show_run(5, "R5 R6 order and wrap");
    show_run(3, "R7 restart from oldest");

    // R4: held strobe
    @(negedge clk);
    mode = 3'b010; plate_in = 5'd11; action = 1'b1;
    repeat (3) @(negedge clk);
    action = 1'b0;
    qa.push_back(5'd11);
    check("R4 single append", cars_a, qa.size());

    // R11: strobes in review mode
    @(negedge clk);
    mode = 3'b110; plate_in = 5'd12; action = 1'b1;
    repeat (2) @(negedge clk);
    action = 1'b0;
    @(negedge clk);
    mode = 3'b000;
    @(negedge clk);
    check("R11 cars_a", cars_a, qa.size());
    check("R11 cars_b", cars_b, qb.size());

    // R10 with R8: midnight wins over a same-cycle violation
    @(negedge clk);
    mode = 3'b000; green_a = 1'b0; action = 1'b1; midnight = 1'b1;
    @(negedge clk);
    action = 1'b0; midnight = 1'b0;
    model_op(3'b000, 5'd0, 0, 0, 1);
    check("R10 output zero", shown, 0);
    check("R10 departure done", cars_a, qa.size());
    show_run(2, "R10 R8 log empty");

    // R8: single entry
    do_op(3'b011, 5'd21, 1, 1);
    do_op(3'b001, 5'd0, 1, 0);
    show_run(4, "R8 single entry");
    pulse_midnight();

    // R12: full road, empty road, full log
    while (qa.size() > 0) do_op(3'b000, 5'd0, 1, 1);
    do_op(3'b000, 5'd0, 0, 1);
    check("R12 empty departure", cars_a, 0);
    for (int i = 0; i < 31; i++) do_op(3'b010, 5'(i % 31 + 1), 1, 1);
    check("R12 full road", cars_a, 30);
    for (int i = 0; i < 30; i++) do_op(3'b000, 5'd0, 0, 1);
    do_op(3'b010, 5'd17, 1, 1);
    do_op(3'b000, 5'd0, 0, 1);
    show_run(32, "R12 log capped R6 wrap");
    pulse_midnight();

    // random mix
    for (int it = 0; it < 400; it++) begin
      int r = $urandom_range(0, 99);
      if (r < 80)
        do_op(3'($urandom_range(0, 3)), 5'($urandom_range(1, 31)),
              1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      else if (r < 93)
        show_run($urandom_range(1, 8), "R6 random review");
      else
        pulse_midnight();
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule